// File: doc/BRIEF.md
# Signed Booth Multiplier with Row-Chained Accumulation

The block multiplies two signed N-bit operands and returns their full signed 2N-bit product. The multiplier operand is recoded into radix-4 Booth digits, one for each pair of bits, so there are ceil(N/2) partial-product rows. Each row is offset by two columns from the row before it. There is no separate compression tree. Each row is added to the running total of the rows above it in its own ripple carry stage. In that stage the carry chain takes the new partial-product bit as its generate term. Its propagate term is that bit XORed with the running-total bit at the same absolute column.

Signed rows are not sign-extended across the full width. The top bit of every row is inverted instead, and a constant correction word is the starting value of the running total ahead of the first row. A negative Booth multiple is formed as the bitwise complement of the selected multiple, and the missing +1 enters as the carry-in at that row's lowest column.

When `REG_ROWS` is 1, a register follows every row, so a new operand pair can be accepted every cycle. When it is 0, all rows are combinational and only the result is registered. An odd N is sign-extended internally to the next even width.

Top module: `booth_chain_mul`

## Requirements
- R1: When `out_valid` is high, `product` equals the exact signed product of the operand pair accepted with it, over the full 2N-bit range.
- R2: With `REG_ROWS`=1 the result appears ceil(N/2) cycles after the cycle in which `in_valid` was sampled high. With `REG_ROWS`=0 it appears one cycle after.
- R3: `out_valid` rises only for accepted pairs, in acceptance order. Pairs presented on back-to-back cycles give results on back-to-back cycles, and idle input cycles give no output.
- R4: While `rst_n` is low, `out_valid` is 0, even if `in_valid` is high.
- R5: Row k takes its digit from multiplier bits (2k+1, 2k, 2k-1), with bit -1 read as 0. The result is -2·b[2k+1] + b[2k] + b[2k-1]. The triplet 111 gives digit 0 and no carry-in.
- R6: A negative digit selects the bitwise complement of X or 2X and sets that row's carry-in to 1.
- R7: Each row adder starts its carry at column 2k. At each column it uses generate = partial-product bit and propagate = that bit XOR running-total bit, so sum = propagate XOR carry, and carry-out = carry if propagate is 1, otherwise the partial-product bit.
- R8: The most significant bit of each row is inverted. The running total starts at -(sum over k of 2^(NE+2k)) mod 2^(2NE), where NE is the even working width.
- R9: Corner operands give exact results: most-negative × most-negative = 2^(2N-2), and most-positive × most-negative.
- R10: An odd N works by sign-extending both operands to N+1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a | input | N | Signed multiplicand |
| b | input | N | Signed multiplier, Booth-recoded |
| out_valid | output | 1 | Product valid |
| product | output | 2N | Signed product |

## Verification
Every accepted pair is due a fixed number of cycles after acceptance: ceil(N/2) cycles for the registered-row build and one cycle for the combinational build. The bench records the due cycle with each expected product. At every falling edge it compares the oldest pending item against `out_valid` and `product`. A missing result in the due cycle fails, and so does a result with nothing due. One instance is N=16 with a register per row, fed directed corner cases and random pairs with random gaps. The other is N=5 with combinational rows, fed every operand pair back to back.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Booth digit as sign plus one-hot magnitude (|d| = 1 or 2; neither = 0)
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

  function automatic int digit_value(booth_dig_t d);
    int mag;
    mag = int'(d.one) + 2 * int'(d.two);
    return d.neg ? -mag : mag;
  endfunction
endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
  import booth_pkg::*;
(
  input  logic [2:0] trip,
  output booth_dig_t dig
);
  always_comb begin
    dig.one = trip[1] ^ trip[0];
    dig.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
    dig.neg = trip[2] & ~(trip[1] & trip[0]);
  end

  always_comb begin
    if (!$isunknown(trip)) begin
      AST_DIGIT_VALUE: assert (digit_value(dig) ==
        (-2 * int'(trip[2]) + int'(trip[1]) + int'(trip[0]))); // R5
      AST_DIGIT_MAG: assert ($onehot0({dig.one, dig.two})); // R5
    end
  end
endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen
  import booth_pkg::*;
#(
  parameter int NE = 16
) (
  input  logic [NE-1:0] x,
  input  booth_dig_t    dig,
  output logic [NE:0]   pp,
  output logic          cin
);
  logic [NE:0] mult;
  logic [NE:0] raw;

  always_comb begin
    if (dig.one)      mult = {x[NE-1], x};
    else if (dig.two) mult = {x, 1'b0};
    else              mult = '0;
    raw = dig.neg ? ~mult : mult;
    pp  = {~raw[NE], raw[NE-1:0]};   // inverted MSB replaces sign extension
    cin = dig.neg;                   // +1 completing the two's complement
  end

  always_comb begin
    if (!$isunknown({x, dig})) begin
      AST_ROW_MULTIPLE: assert (int'($signed({~pp[NE], pp[NE-1:0]})) + int'(cin)
        == digit_value(dig) * int'($signed(x))); // R6
    end
  end
endmodule

// File: rtl/booth_row_adder.sv
module booth_row_adder #(
  parameter int NE  = 16,
  parameter int W   = 32,
  parameter int OFS = 0
) (
  input  logic [W-1:0] acc_in,
  input  logic [NE:0]  pp,
  input  logic         cin,
  output logic [W-1:0] acc_out
);
  logic [W-1:0] pp_ext;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  assign pp_ext = W'(pp) << OFS;

  always_comb begin
    carry = '0;
    prop  = '0;
    carry[OFS] = cin;
    for (int j = 0; j < W; j++) begin
      if (j < OFS) begin
        acc_out[j] = acc_in[j];
      end else begin
        prop[j]      = acc_in[j] ^ pp_ext[j];
        acc_out[j]   = prop[j] ^ carry[j];
        carry[j+1]   = prop[j] ? carry[j] : pp_ext[j];
      end
    end
  end

  always_comb begin
    if (!$isunknown({acc_in, pp, cin})) begin
      AST_ROW_SUM: assert (acc_out == W'(acc_in + pp_ext + (W'(cin) << OFS))); // R7
    end
  end
endmodule

// File: rtl/booth_chain_mul.sv
module booth_chain_mul
  import booth_pkg::*;
#(
  parameter int N        = 16,
  parameter bit REG_ROWS = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           out_valid,
  output logic [2*N-1:0] product
);
  localparam int NE = N + (N % 2);
  localparam int R  = NE / 2;
  localparam int P  = 2 * NE;

  function automatic logic [P-1:0] sext_corr();
    logic [P-1:0] c;
    c = '0;
    for (int k = 0; k < R; k++) c = c - (P'(1) << (NE + 2 * k));
    return c;
  endfunction

  localparam logic [P-1:0] CORR = sext_corr();

  logic [NE-1:0] x_s   [R+1];
  logic [NE-1:0] y_s   [R+1];
  logic [P-1:0]  acc_s [R+1];
  logic          vld_s [R+1];

  assign x_s[0]   = NE'($signed(a));
  assign y_s[0]   = NE'($signed(b));
  assign acc_s[0] = CORR;            // R8: correction injected before first row
  assign vld_s[0] = in_valid;

  for (genvar r = 0; r < R; r++) begin : g_row
    logic [2:0]  trip;
    booth_dig_t  dig;
    logic [NE:0] pp;
    logic        cin;
    logic [P-1:0] acc_row;

    if (r == 0) begin : g_first
      assign trip = {y_s[r][1], y_s[r][0], 1'b0};
    end else begin : g_next
      assign trip = {y_s[r][2*r+1], y_s[r][2*r], y_s[r][2*r-1]};
    end

    booth_digit_enc i_enc (.trip(trip), .dig(dig));

    booth_row_gen #(.NE(NE)) i_gen (
      .x(x_s[r]), .dig(dig), .pp(pp), .cin(cin)
    );

    booth_row_adder #(.NE(NE), .W(P), .OFS(2 * r)) i_add (
      .acc_in(acc_s[r]), .pp(pp), .cin(cin), .acc_out(acc_row)
    );

    if (REG_ROWS || r == R - 1) begin : g_reg
      logic          vld_d, vld_q;
      logic [NE-1:0] x_d, x_q, y_d, y_q;
      logic [P-1:0]  acc_d, acc_q;

      always_comb begin
        vld_d = vld_s[r];
        x_d   = x_q;
        y_d   = y_q;
        acc_d = acc_q;
        if (vld_s[r]) begin
          x_d   = x_s[r];
          y_d   = y_s[r];
          acc_d = acc_row;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
      end

      always_ff @(posedge clk) begin
        x_q   <= x_d;
        y_q   <= y_d;
        acc_q <= acc_d;
      end

      assign vld_s[r+1] = vld_q;
      assign x_s[r+1]   = x_q;
      assign y_s[r+1]   = y_q;
      assign acc_s[r+1] = acc_q;
    end else begin : g_pass
      assign vld_s[r+1] = vld_s[r];
      assign x_s[r+1]   = x_s[r];
      assign y_s[r+1]   = y_s[r];
      assign acc_s[r+1] = acc_row;
    end
  end

  assign out_valid = vld_s[R];
  assign product   = acc_s[R][2*N-1:0];

  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(product) ==
      ($signed(x_s[R][N-1:0]) * $signed(y_s[R][N-1:0])))); // R1

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!out_valid); // R4
    end
  end
endmodule

// File: tb/test_booth_chain_mul.sv
`timescale 1ns/1ps
module test_booth_chain_mul;
  localparam int NA   = 16;
  localparam int NB   = 5;
  localparam int LATA = (NA + 1) / 2;
  localparam int LATB = 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic            va, vb;
  logic [NA-1:0]   aa, ba;
  logic [NB-1:0]   ab, bb;
  logic            ova, ovb;
  logic [2*NA-1:0] pa;
  logic [2*NB-1:0] pb;

  booth_chain_mul #(.N(NA), .REG_ROWS(1'b1)) i_booth_chain_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(va), .a(aa), .b(ba),
    .out_valid(ova), .product(pa)
  );

  booth_chain_mul #(.N(NB), .REG_ROWS(1'b0)) i_booth_chain_mul_n5 (
    .clk(clk), .rst_n(rst_n), .in_valid(vb), .a(ab), .b(bb),
    .out_valid(ovb), .product(pb)
  );

  typedef struct {
    longint x;
    longint y;
    int     due;
    string  tag;
  } item_t;

  item_t qa[$];
  item_t qb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic drive_a(longint x, longint y, string tag);
    @(negedge clk);
    va = 1'b1;
    aa = x[NA-1:0];
    ba = y[NA-1:0];
    qa.push_back('{x, y, cyc + LATA, tag});
  endtask

  task automatic idle_a();
    @(negedge clk);
    va = 1'b0;
  endtask

  task automatic drive_b(longint x, longint y, string tag);
    @(negedge clk);
    vb = 1'b1;
    ab = x[NB-1:0];
    bb = y[NB-1:0];
    qb.push_back('{x, y, cyc + LATB, tag});
  endtask

  // monitors: R2 timing, R3 ordering/no spurious output, tag per item
  always @(negedge clk) begin
    if (mon_on) begin
      if (qa.size() > 0 && qa[0].due == cyc) begin
        check(ova, "R2", longint'(ova), 1);
        if (ova) check($signed(pa) == qa[0].x * qa[0].y, qa[0].tag,
                       longint'($signed(pa)), qa[0].x * qa[0].y);
        void'(qa.pop_front());
      end else if (ova) begin
        check(1'b0, "R3", 1, 0);
      end
      if (qb.size() > 0 && qb[0].due == cyc) begin
        check(ovb, "R2", longint'(ovb), 1);
        if (ovb) check($signed(pb) == qb[0].x * qb[0].y, qb[0].tag,
                       longint'($signed(pb)), qb[0].x * qb[0].y);
        void'(qb.pop_front());
      end else if (ovb) begin
        check(1'b0, "R3", 1, 0);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    va = 1'b1; vb = 1'b1;
    aa = 16'h1234; ba = 16'h0F0F; ab = 5'h3; bb = 5'h7;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!ova && !ovb, "R4", longint'({ova, ovb}), 0);
    end
    va = 1'b0; vb = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    fork
      begin
        drive_a(-32768, -32768, "R9");
        drive_a(32767, -32768, "R9");
        drive_a(32767, 32767, "R9");
        drive_a(-1, -1, "R5");
        drive_a(12345, -1, "R5");
        drive_a(-21846, -21846, "R6");
        drive_a(29, -21846, "R6");
        drive_a(-1, 21845, "R7");
        drive_a(65535 - 65536, 32767, "R7");
        drive_a(-12345, 6789, "R8");
        drive_a(-7, -3, "R8");
        drive_a(0, -5, "R1");
        idle_a();
        idle_a();
        for (int i = 0; i < 3000; i++) begin
          drive_a(longint'($signed(16'($urandom))), longint'($signed(16'($urandom))), "R1");
          if (($urandom % 4) == 0) begin
            idle_a();
            drive_a(longint'($signed(16'($urandom))), -32768, "R3");
          end
          if (($urandom % 5) == 0) begin
            for (int k = 0; k < int'($urandom % 3) + 1; k++) idle_a();
          end
        end
        idle_a();
      end
      begin
        for (int x = -16; x < 16; x++) begin
          for (int y = -16; y < 16; y++) begin
            drive_b(longint'(x), longint'(y), "R10");
          end
        end
        @(negedge clk);
        vb = 1'b0;
      end
    join

    while (qa.size() > 0 || qb.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", qa.size() + qb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule